// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is a single 16-bit control and status word for an instrument on a host bus. It records two kinds of events in sticky pending flags: a one-cycle burst-complete pulse, and a low-to-high transition of a ready line. Software enables each source separately, sets a global enable, and picks how an interrupt is retired. The block drives one interrupt request line from these flags and enables.

The word is read and written through a plain synchronous port. A write loads the enable and mode fields, and writing a 1 to a pending flag clears that flag. Four clock-lock status inputs are passed straight into the readback word; writes do not affect them. An acknowledge strobe from the bus side is handled according to the mode. In hardware-retire mode the block drives the low byte of the word as a vector during the acknowledge cycle and then clears its own global enable. In software-retire mode the acknowledge is ignored.

Top module: `irq_ctl_reg`

## Requirements
- R1: While reset is held and in the first cycle after it, readback bits 15, 8, 5, 4, 1 and 0 are 0 and `irqReq` is 0. The one exception is bit 4, which may set in the first cycle after reset through the R4 edge rule.
- R2: A cycle with `wrEn` high loads the fields from `wrData`: bit 15 is the global enable, bit 8 is the retire mode (0 = software, 1 = hardware), bit 1 is the burst enable and bit 0 is the ready enable. From the next cycle these fields read back at the same bit positions of `rdData`.
- R3: If `burstDone` is high in a cycle, `rdData` bit 5 (burst pending) is 1 from the next cycle on.
- R4: `readyIn` is sampled into a register once per clock, and that register resets to 0. A cycle where `readyIn` is 1 and the register holds 0 sets `rdData` bit 4 (ready pending) from the next cycle on. Holding `readyIn` high sets nothing further.
- R5: A write with bit 5 or bit 4 at 1 clears the matching pending flag, and a write with 0 in that position leaves it unchanged. If an event arrives for a flag in the same cycle as a clear of that flag, the flag stays 1.
- R6: `irqReq` = bit15 AND ((bit5 AND bit1) OR (bit4 AND bit0)), taken over the current register contents.
- R7: `rdData` bits 13..10 always equal `lockFlags[3:0]`, with `lockFlags[3]` at bit 13. Here 1 means not locked. Writes do not change these bits.
- R8: `rdData` bits 14, 9, 7, 6, 3 and 2 always read 0.
- R9: While `ackStrobe` is high and the mode bit is 1, `irqVector` equals `rdData[7:0]`. At all other times `irqVector` is 0.
- R10: An acknowledge in hardware mode clears the global enable from the next cycle. If a write arrives in the same cycle, the written bit 15 is loaded instead.
- R11: In software mode an acknowledge changes no register, and `irqReq` stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Current readback word |
| burstDone | input | 1 | Burst-complete event pulse |
| readyIn | input | 1 | Ready level; its rising edge is an event |
| lockFlags | input | 4 | Clock-lock status, 1 = not locked |
| ackStrobe | input | 1 | Interrupt acknowledge cycle |
| irqVector | output | 8 | Vector driven during a hardware-mode acknowledge |
| irqReq | output | 1 | Interrupt request |

## Verification
Several rules are checked on every cycle: the request equation against the readback word, the event-to-pending latency, clear-with-event priority, lock passthrough, reserved zeros, the vector gating, and the disarm after a hardware-mode acknowledge. Some behaviour can only be shown by the bench's scenarios. These are the exhaustive sweep of all mode, enable and pending combinations through acknowledge, the edge detector's prior-low rule right after reset, the absence of a re-trigger while ready is held high, and write-over-acknowledge priority.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int DATA_W   = 16;
  localparam int VEC_W    = 8;
  localparam int NUM_LOCK = 4;
  localparam int NUM_SRC  = 2;

  // readback field positions (the vector decoder depends on the low byte)
  localparam int POS_MASTER   = 15;
  localparam int POS_TYPE     = 8;
  localparam int POS_LOCK_LSB = 10;
  localparam int POS_PEND_LSB = 4;
  localparam int POS_EN_LSB   = 0;

  // source 0 = ready (edge detected), source 1 = burst done (pulse)
  localparam int SRC_RDY = 0;
  localparam int SRC_EOB = 1;
  localparam logic [NUM_SRC-1:0] SRC_IS_EDGE = 2'b01;

  typedef struct packed {
    logic               cfgLoad;
    logic               cfgMaster;
    logic               cfgType;
    logic [NUM_SRC-1:0] cfgEn;
    logic [NUM_SRC-1:0] pendClr;
    logic               ackDisarm;
    logic               vecDrive;
  } ctlStrb_t;
endpackage

// File: rtl/irq_ctl_ctrl.sv
module irq_ctl_ctrl
  import irq_ctl_pkg::*;
(
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ackStrobe,
  input  logic              typeQ,
  output ctlStrb_t          strb
);
  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[14:9], wrData[7:6], wrData[3:2]};

  always_comb begin
    strb           = '0;
    strb.cfgLoad   = wrEn;
    strb.cfgMaster = wrData[POS_MASTER];
    strb.cfgType   = wrData[POS_TYPE];
    for (int i = 0; i < NUM_SRC; i++) begin
      strb.cfgEn[i]   = wrData[POS_EN_LSB + i];
      strb.pendClr[i] = wrEn & wrData[POS_PEND_LSB + i];
    end
    strb.ackDisarm = ackStrobe & typeQ;
    strb.vecDrive  = ackStrobe & typeQ;
  end
endmodule

// File: rtl/irq_ctl_dp.sv
module irq_ctl_dp
  import irq_ctl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrb_t            strb,
  input  logic [NUM_SRC-1:0]  srcIn,
  input  logic [NUM_LOCK-1:0] lockFlags,
  output logic                typeQ,
  output logic [DATA_W-1:0]   rdData,
  output logic [VEC_W-1:0]    irqVector,
  output logic                irqReq
);
  logic               masterQ;
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] pendQ;
  logic [NUM_SRC-1:0] evt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterQ <= 1'b0;
      typeQ   <= 1'b0;
      enQ     <= '0;
    end else if (strb.cfgLoad) begin
      masterQ <= strb.cfgMaster;
      typeQ   <= strb.cfgType;
      enQ     <= strb.cfgEn;
    end else if (strb.ackDisarm) begin
      masterQ <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (SRC_IS_EDGE[i]) begin : g_edge
      logic prevQ;
      always_ff @(posedge clk) begin
        if (!rstN) prevQ <= 1'b0;
        else       prevQ <= srcIn[i];
      end
      assign evt[i] = srcIn[i] & ~prevQ;
    end else begin : g_pulse
      assign evt[i] = srcIn[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) pendQ[i] <= 1'b0;
      else       pendQ[i] <= evt[i] | (pendQ[i] & ~strb.pendClr[i]);
    end
  end

  always_comb begin
    rdData = '0;
    rdData[POS_MASTER] = masterQ;
    rdData[POS_TYPE]   = typeQ;
    rdData[POS_LOCK_LSB +: NUM_LOCK] = lockFlags;
    for (int i = 0; i < NUM_SRC; i++) begin
      rdData[POS_PEND_LSB + i] = pendQ[i];
      rdData[POS_EN_LSB + i]   = enQ[i];
    end
  end

  assign irqReq    = masterQ & |(pendQ & enQ);
  assign irqVector = strb.vecDrive ? rdData[VEC_W-1:0] : '0;
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import irq_ctl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic                burstDone,
  input  logic                readyIn,
  input  logic [NUM_LOCK-1:0] lockFlags,
  input  logic                ackStrobe,
  output logic [VEC_W-1:0]    irqVector,
  output logic                irqReq
);
  ctlStrb_t           strb;
  logic               typeQ;
  logic [NUM_SRC-1:0] srcIn;

  always_comb begin
    srcIn          = '0;
    srcIn[SRC_RDY] = readyIn;
    srcIn[SRC_EOB] = burstDone;
  end

  irq_ctl_ctrl ctrl_i (
    .wrEn(wrEn), .wrData(wrData), .ackStrobe(ackStrobe),
    .typeQ(typeQ), .strb(strb)
  );

  irq_ctl_dp dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .srcIn(srcIn),
    .lockFlags(lockFlags), .typeQ(typeQ), .rdData(rdData),
    .irqVector(irqVector), .irqReq(irqReq)
  );
endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        burstDone,
  input logic        readyIn,
  input logic [3:0]  lockFlags,
  input logic        ackStrobe,
  input logic [7:0]  irqVector,
  input logic        irqReq
);
  logic unusedChk;
  assign unusedChk = ^{wrData[14:9], wrData[7:6], wrData[3:2]};

  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ({rdData[15], rdData[8], rdData[1:0]} ==
              {$past(wrData[15]), $past(wrData[8]), $past(wrData[1:0])}));

  assert_eob_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> rdData[5]);

  assert_rdy_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyIn) |=> rdData[4]);

  assert_eob_clr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[5] && !burstDone) |=> !rdData[5]);

  assert_req_eq_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (rdData[15] && ((rdData[5] && rdData[1]) || (rdData[4] && rdData[0]))));

  assert_lock_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdData[13:10] == lockFlags);

  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & 16'h42CC) == 16'h0000);

  assert_vec_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqVector == ((ackStrobe && rdData[8]) ? rdData[7:0] : 8'h00));

  assert_hw_disarm_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && rdData[8] && !wrEn) |=> !rdData[15]);

  assert_sw_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !rdData[8] && !wrEn) |=> rdData[15] == $past(rdData[15]));
endmodule

bind irq_ctl_reg irq_ctl_chk chk_i (.*);

// File: tb/irq_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module irq_ctl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        burstDone = 1'b0;
  logic        readyIn = 1'b0;
  logic [3:0]  lockFlags = 4'h0;
  logic        ackStrobe = 1'b0;
  logic [7:0]  irqVector;
  logic        irqReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irq_ctl_reg dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseBurst();
    @(negedge clk); burstDone = 1'b1;
    @(negedge clk); burstDone = 1'b0;
  endtask

  task automatic pulseReady();
    @(negedge clk); readyIn = 1'b1;
    @(negedge clk); readyIn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with readyIn held high to test the R4 prior-low rule
    readyIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset word", 32'(rdData & 16'h8133), 32'h0);
    chk("R1 reset irqReq", 32'(irqReq), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R4 first cycle after reset prior low", 32'(rdData[4]), 32'h1);
    chk("R1 config after reset", 32'(rdData & 16'h8123), 32'h0);
    // R4: held-high readyIn does not set the flag again after a clear
    writeReg(16'h0010);
    repeat (3) @(negedge clk);
    chk("R4 steady high no retrigger", 32'(rdData[4]), 32'h0);
    readyIn = 1'b0;
    @(negedge clk);

    // R5: writing zero leaves pending intact; event and clear together keeps flag set
    pulseBurst();
    writeReg(16'h0000);
    chk("R5 write zero no effect", 32'(rdData[5]), 32'h1);
    @(negedge clk); wrEn = 1'b1; wrData = 16'h0020; burstDone = 1'b1;
    @(negedge clk); wrEn = 1'b0; wrData = '0; burstDone = 1'b0;
    chk("R5 event beats clear", 32'(rdData[5]), 32'h1);
    writeReg(16'h0020);
    chk("R5 clear by one", 32'(rdData[5]), 32'h0);

    // R7: writes cannot touch lock bits
    lockFlags = 4'hA;
    writeReg(16'hFFFF);
    chk("R7 lock readonly", 32'(rdData[13:10]), 32'hA);
    chk("R8 reserved zero after all-ones write", 32'(rdData & 16'h42CC), 32'h0);

    // R10: write during hardware acknowledge wins
    writeReg(16'h0130);
    @(negedge clk); ackStrobe = 1'b1; wrEn = 1'b1; wrData = 16'h8100;
    @(negedge clk); ackStrobe = 1'b0; wrEn = 1'b0; wrData = '0;
    chk("R10 write priority over ack", 32'(rdData[15]), 32'h1);

    // exhaustive sweep: mode/enables x pending flags
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int pend = 0; pend < 4; pend++) begin
        logic m, t, e, r, pe, pr;
        logic [15:0] expWord;
        logic [3:0] lk;
        m = cfg[3]; t = cfg[2]; e = cfg[1]; r = cfg[0];
        pr = pend[0]; pe = pend[1];
        lk = 4'(cfg) ^ 4'(pend * 5);
        writeReg(16'h0030);
        if (pr) pulseReady();
        if (pe) pulseBurst();
        lockFlags = lk;
        writeReg({m, 6'b0, t, 6'b0, e, r});
        expWord = {m, 1'b0, lk, 1'b0, t, 2'b00, pe, pr, 2'b00, e, r};
        chk("R2 R3 R4 R7 R8 readback", 32'(rdData), 32'(expWord));
        chk("R6 request", 32'(irqReq), 32'(m & ((pe & e) | (pr & r))));
        @(negedge clk); ackStrobe = 1'b1;
        #1;
        chk("R9 vector", 32'(irqVector), t ? 32'(expWord[7:0]) : 32'h0);
        @(negedge clk); ackStrobe = 1'b0;
        #1;
        if (t) chk("R10 hw ack disarms", 32'(rdData[15]), 32'h0);
        else   chk("R11 sw ack no change", 32'(rdData), 32'(expWord));
        chk("R6 R10 R11 request after ack", 32'(irqReq),
            32'((t ? 1'b0 : m) & ((pe & e) | (pr & r))));
        chk("R9 vector idle", 32'(irqVector), 32'h0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule